// File: doc/BRIEF.md
# Glitch-Free Synchronous Clock Stop Gate

This block drives a group of gated clock outputs and one free-running sibling. All of them come from a divided clock that the block makes itself by toggling a phase flop every `DIV_HALF` cycles of the reference clock `clk`. An active-low stop request `stop_n` may arrive at any time, with no relation to `clk`. It passes through a flop synchronizer and then steers a small state machine. That machine decides when the gated group is parked low and when it restarts. Each gated output also has its own enable bit, and the free-running output has one too. The stop request never touches the free-running output.

The state machine has four states:
- `GS_HOLD`: running, with the minimum-enable window still being counted.
- `GS_HOLD_PEND`: running, with a stop request seen during the window and recorded.
- `GS_RUN`: running, and free to stop.
- `GS_STOPPED`: gated outputs parked low.

Its transitions are:
- reset enters `GS_HOLD`.
- `GS_HOLD` goes to `GS_HOLD_PEND` on a stop request inside the window.
- `GS_HOLD` goes to `GS_RUN` when the window ends with no request.
- `GS_HOLD` goes to `GS_STOPPED` when the window ends while a request is present.
- `GS_HOLD_PEND` goes to `GS_STOPPED` when the window ends.
- `GS_RUN` goes to `GS_STOPPED` on a request.
- `GS_STOPPED` goes to `GS_HOLD` when the request is gone.

Every move into or out of `GS_STOPPED` is taken only on the falling edge of the divided clock. Enable bits are loaded at that same edge. As a result, outputs always park while low and always come back with a complete high phase. Each output is a single flop, loaded with the next divided phase ANDed with the next gate and enable values.

The same block serves two clock groups through its parameters. A processor-side group uses `MIN_ON = 100`, and its stop and start latencies stay below four divided periods. A bus-side group uses `MIN_ON = 10`, which is the default.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every output is 0. After release, every output runs with a period of 2*DIV_HALF reference cycles, and the state machine starts in `GS_HOLD`.
- R2: `stop_n` is asynchronous and active low, and is taken through a SYNC_STAGES flop synchronizer (default 2). Once the minimum window has passed, no gated output is high later than 2+2*DIV_HALF reference cycles after `stop_n` falls. The gated outputs then stay at 0 for as long as `stop_n` stays low.
- R3: From `GS_STOPPED`, the first high phase of a gated output appears no later than 2+3*DIV_HALF reference cycles after `stop_n` rises.
- R4: Every high phase on every output lasts exactly DIV_HALF reference cycles, across stops, restarts and enable changes. The gate state changes only while the divided clock is low.
- R5: After reset or after any restart, the gated group produces at least MIN_ON full high pulses before a stop is honoured. With `stop_n` held low from the restart onward, it produces exactly MIN_ON pulses.
- R6: A stop request that appears during the minimum window and goes away again is still recorded. Exactly MIN_ON pulses are produced, then the outputs park low for at least one divided period, and then they restart because the request is gone.
- R7: `clk_free` keeps running while `stop_n` is low.
- R8: `out_en[i] = 0` holds `clk_out[i]` at 0, and `free_en = 0` holds `clk_free` at 0 (bit value 1 means enabled). A change is loaded at the next falling edge of the divided clock, so a high phase already in progress completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request for the gated group |
| out_en | input | N_OUT | Per-lane enable, 1 = running |
| free_en | input | 1 | Enable of the free-running output, 1 = running |
| clk_out | output | N_OUT | Gated divided clock outputs |
| clk_free | output | 1 | Free-running divided clock output |

## Verification
The hardest situation to reach is a short stop request that lands inside the minimum-enable window and is already gone when the window closes. It is visible only as a lone gap in the pulse train. The stimulus first holds the block stopped, then releases `stop_n`, then pulses it low for four reference cycles a few periods later. The bench counts pulses up to the first low stretch longer than DIV_HALF and confirms that pulses resume after that stretch. The stop and start latencies are measured at four phase offsets of `stop_n` against the divided clock, so that every arrival point inside a period is covered.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    typedef enum logic [1:0] {
        GS_HOLD      = 2'd0,
        GS_HOLD_PEND = 2'd1,
        GS_RUN       = 2'd2,
        GS_STOPPED   = 2'd3
    } gate_state_e;

endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/1ps
// Flop chain that brings the asynchronous active-low stop request into clk.
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_async,
    output logic req
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], req_n_async};
        end
    end

    assign req = ~chain_q[STAGES-1];

endmodule

// File: rtl/toggle_div.sv
`timescale 1ns/1ps
// Divided clock: phase flop toggles every DIV_HALF reference cycles.
module toggle_div #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic dclk,
    output logic dclk_nxt,
    output logic fall_evt
);

    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic tick;
    logic dclk_q;

    generate
        if (DIV_HALF == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (tick) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick = (cnt_q == CW'(DIV_HALF - 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dclk_q <= 1'b0;
        end else begin
            dclk_q <= dclk_nxt;
        end
    end

    assign dclk_nxt = tick ? ~dclk_q : dclk_q;
    assign fall_evt = tick & dclk_q;
    assign dclk     = dclk_q;

endmodule

// File: rtl/stop_fsm.sv
`timescale 1ns/1ps
// Stop/start sequencer; moves only at falling edges of the divided clock.
module stop_fsm
    import clkgate_pkg::*;
#(
    parameter int MIN_ON = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop_req,
    input  logic        fall_evt,
    output gate_state_e state,
    output logic        run,
    output logic        run_nxt
);

    localparam int CW = $clog2(MIN_ON + 1);

    gate_state_e   state_q;
    gate_state_e   state_d;
    logic [CW-1:0] win_q;
    logic          win_done;
    logic          holding;

    assign win_done = (win_q == CW'(MIN_ON - 1));
    assign holding  = (state_q == GS_HOLD) || (state_q == GS_HOLD_PEND);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_HOLD: begin
                if (fall_evt && win_done) begin
                    state_d = stop_req ? GS_STOPPED : GS_RUN;
                end else if (stop_req) begin
                    state_d = GS_HOLD_PEND;
                end
            end
            GS_HOLD_PEND: begin
                if (fall_evt && win_done) begin
                    state_d = GS_STOPPED;
                end
            end
            GS_RUN: begin
                if (fall_evt && stop_req) begin
                    state_d = GS_STOPPED;
                end
            end
            GS_STOPPED: begin
                if (fall_evt && !stop_req) begin
                    state_d = GS_HOLD;
                end
            end
            default: state_d = GS_HOLD;
        endcase
    end

    assign run_nxt = (state_d != GS_STOPPED);

    // outputs: gate flag and minimum-window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run   <= 1'b1;
            win_q <= '0;
        end else begin
            run <= run_nxt;
            if (state_q == GS_STOPPED) begin
                win_q <= '0;
            end else if (holding && fall_evt && !win_done) begin
                win_q <= win_q + 1'b1;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/out_gate.sv
`timescale 1ns/1ps
// Per-lane enable capture and registered output flops.
module out_gate #(
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_evt,
    input  logic             dclk_nxt,
    input  logic             run_nxt,
    input  logic [N_OUT-1:0] out_en,
    input  logic             free_en,
    output logic [N_OUT-1:0] clk_out,
    output logic             clk_free
);

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_lane
            logic en_q;
            logic o_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q <= 1'b1;
                    o_q  <= 1'b0;
                end else begin
                    if (fall_evt) begin
                        en_q <= out_en[i];
                    end
                    o_q <= dclk_nxt & run_nxt & (fall_evt ? out_en[i] : en_q);
                end
            end
            assign clk_out[i] = o_q;
        end
    endgenerate

    logic fen_q;
    logic free_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fen_q  <= 1'b1;
            free_q <= 1'b0;
        end else begin
            if (fall_evt) begin
                fen_q <= free_en;
            end
            free_q <= dclk_nxt & (fall_evt ? free_en : fen_q);
        end
    end

    assign clk_free = free_q;

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
    import clkgate_pkg::*;
#(
    parameter int N_OUT       = 4,
    parameter int DIV_HALF    = 2,
    parameter int MIN_ON      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_n,
    input  logic [N_OUT-1:0] out_en,
    input  logic             free_en,
    output logic [N_OUT-1:0] clk_out,
    output logic             clk_free
);

    logic        stop_req;
    logic        div_clk;
    logic        div_nxt;
    logic        fall_evt;
    logic        run_q;
    logic        run_nxt;
    gate_state_e fsm_state;

    stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_n_async (stop_n),
        .req         (stop_req)
    );

    toggle_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .dclk     (div_clk),
        .dclk_nxt (div_nxt),
        .fall_evt (fall_evt)
    );

    stop_fsm #(.MIN_ON(MIN_ON)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .fall_evt (fall_evt),
        .state    (fsm_state),
        .run      (run_q),
        .run_nxt  (run_nxt)
    );

    out_gate #(.N_OUT(N_OUT)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_evt (fall_evt),
        .dclk_nxt (div_nxt),
        .run_nxt  (run_nxt),
        .out_en   (out_en),
        .free_en  (free_en),
        .clk_out  (clk_out),
        .clk_free (clk_free)
    );

endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk
    import clkgate_pkg::*;
#(
    parameter int N_OUT    = 4,
    parameter int DIV_HALF = 2,
    parameter int MIN_ON   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input gate_state_e      state,
    input logic             run,
    input logic             dclk,
    input logic [N_OUT-1:0] clk_out,
    input logic             clk_free
);

    localparam int HW = $clog2(DIV_HALF + 2);
    localparam int PW = $clog2(MIN_ON + 1);

    logic [N_OUT:0] lanes;
    assign lanes = {clk_free, clk_out};

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (lanes == '0)
                else $error("outputs active during reset");
        end
    end

    assert_parked_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GS_STOPPED) |-> (clk_out == '0))
        else $error("gated lane high while stopped");

    assert_gate_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run) |-> !dclk)
        else $error("gate changed outside low phase");

    generate
        for (genvar i = 0; i <= N_OUT; i++) begin : g_width
            logic [HW-1:0] hi_len;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hi_len <= '0;
                end else if (lanes[i]) begin
                    if (hi_len != '1) begin
                        hi_len <= hi_len + 1'b1;
                    end
                end else begin
                    hi_len <= '0;
                end
            end
            assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(lanes[i]) |-> (hi_len == HW'(DIV_HALF)))
                else $error("runt or stretched high phase on lane %0d", i);
        end
    endgenerate

    logic          dclk_prev;
    logic [PW-1:0] on_pulses;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dclk_prev <= 1'b0;
            on_pulses <= '0;
        end else begin
            dclk_prev <= dclk;
            if (!run) begin
                on_pulses <= '0;
            end else if (dclk && !dclk_prev && (on_pulses != PW'(MIN_ON))) begin
                on_pulses <= on_pulses + 1'b1;
            end
        end
    end

    assert_min_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> (on_pulses >= PW'(MIN_ON)))
        else $error("stop honoured before minimum enable window");

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
    .N_OUT    (N_OUT),
    .DIV_HALF (DIV_HALF),
    .MIN_ON   (MIN_ON)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fsm_state),
    .run      (run_q),
    .dclk     (div_clk),
    .clk_out  (clk_out),
    .clk_free (clk_free)
);

// File: tb/tb_clk_stop_gate.sv
`timescale 1ns/1ps
module tb_clk_stop_gate;

    localparam int N  = 4;
    localparam int DH = 2;
    localparam int MO = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         stop_n;
    logic [N-1:0] out_en;
    logic         free_en;
    logic [N-1:0] clk_out;
    logic         clk_free;

    int checks   = 0;
    int failures = 0;
    int width_errs  = 0;
    int pulses_seen = 0;
    int hi_run [N+1];
    logic mon_en = 1'b0;

    always #2 clk = ~clk;

    clk_stop_gate #(
        .N_OUT(N), .DIV_HALF(DH), .MIN_ON(MO), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .stop_n(stop_n), .out_en(out_en),
        .free_en(free_en), .clk_out(clk_out), .clk_free(clk_free)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R4 monitor: every high run on every lane must be DH samples long
    always @(negedge clk) begin
        if (mon_en) begin
            for (int i = 0; i <= N; i++) begin
                logic v;
                v = (i == N) ? clk_free : clk_out[i];
                if (v) begin
                    hi_run[i]++;
                end else begin
                    if (hi_run[i] > 0) begin
                        pulses_seen++;
                        if (hi_run[i] != DH) width_errs++;
                    end
                    hi_run[i] = 0;
                end
            end
        end
    end

    // {stop_n, out_en[3:0], free_en, expected gated[3:0], expected free}
    localparam logic [10:0] VEC [8] = '{
        11'b1_1111_1_1111_1,
        11'b1_1010_1_1010_1,
        11'b0_1111_1_0000_1,
        11'b0_0101_0_0000_0,
        11'b1_0101_0_0101_0,
        11'b1_0000_1_0000_1,
        11'b0_0000_1_0000_1,
        11'b1_0110_1_0110_1
    };

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] seen_hi, seen_lo;
        logic fhi, flo, prev;
        int r1, r2, last_hi, first_hi, cnt, lowrun, k;
        bit started, gap, resumed, found;

        for (int i = 0; i <= N; i++) hi_run[i] = 0;
        rst_n = 1'b0; stop_n = 1'b1; out_en = '1; free_en = 1'b1;

        // R1: outputs low while in reset
        repeat (5) begin
            @(negedge clk);
            check(clk_out == '0 && !clk_free, "R1", "outputs during reset",
                  int'({clk_free, clk_out}), 0);
        end
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R1: period after release
        r1 = 0; r2 = 0; prev = 1'b0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (clk_free && !prev) begin
                if (r1 == 0) r1 = i;
                else if (r2 == 0) r2 = i;
            end
            prev = clk_free;
        end
        check(r1 != 0 && (r2 - r1) == 2 * DH, "R1", "divided period", r2 - r1, 2 * DH);

        // vector table: R2 R7 R8
        for (int v = 0; v < 8; v++) begin
            stop_n  = VEC[v][10];
            out_en  = VEC[v][9:6];
            free_en = VEC[v][5];
            repeat (80) @(negedge clk);
            seen_hi = '0; seen_lo = '0; fhi = 1'b0; flo = 1'b0;
            repeat (8) begin
                @(negedge clk);
                seen_hi |= clk_out;
                seen_lo |= ~clk_out;
                fhi |= clk_free;
                flo |= ~clk_free;
            end
            check(seen_hi == VEC[v][4:1] && seen_lo == '1, "R2 R8",
                  $sformatf("vector %0d gated lanes", v), int'(seen_hi), int'(VEC[v][4:1]));
            check(fhi == VEC[v][0] && flo, "R7 R8",
                  $sformatf("vector %0d free lane", v), int'(fhi), int'(VEC[v][0]));
        end

        // R2 / R3 latencies at four phase offsets
        out_en = '1; free_en = 1'b1; stop_n = 1'b1;
        repeat (80) @(negedge clk);
        for (int off = 0; off < 4; off++) begin
            repeat (off) @(negedge clk);
            stop_n = 1'b0; last_hi = 0; fhi = 1'b0; flo = 1'b0;
            for (int j = 1; j <= 40; j++) begin
                @(negedge clk);
                if (|clk_out) last_hi = j;
                fhi |= clk_free; flo |= ~clk_free;
            end
            check(last_hi <= 2 + 2 * DH, "R2", "stop latency", last_hi, 2 + 2 * DH);
            check(fhi && flo, "R7", "free lane while stopped", int'(fhi), 1);
            stop_n = 1'b1; first_hi = 0;
            for (int j = 1; j <= 20; j++) begin
                @(negedge clk);
                if (first_hi == 0 && clk_out[0]) first_hi = j;
            end
            check(first_hi >= 1 && first_hi <= 2 + 3 * DH, "R3", "restart latency",
                  first_hi, 2 + 3 * DH);
            repeat (60) @(negedge clk);
        end

        // R5: stop held low right after restart -> exactly MO pulses
        stop_n = 1'b0;
        repeat (20) @(negedge clk);
        stop_n = 1'b1; cnt = 0; prev = 1'b0;
        for (int j = 1; j <= 120; j++) begin
            @(negedge clk);
            if (j == 8) stop_n = 1'b0;
            if (clk_out[0] && !prev) cnt++;
            prev = clk_out[0];
        end
        check(cnt == MO, "R5", "pulses before honoured stop", cnt, MO);

        // R6: short stop pulse inside the window is latched
        stop_n = 1'b1; cnt = 0; prev = 1'b0; lowrun = 0;
        started = 1'b0; gap = 1'b0; resumed = 1'b0;
        for (int j = 1; j <= 200; j++) begin
            @(negedge clk);
            if (j == 16) stop_n = 1'b0;
            if (j == 20) stop_n = 1'b1;
            if (clk_out[0]) begin
                if (!prev) begin
                    if (!gap) cnt++;
                    else resumed = 1'b1;
                    started = 1'b1;
                end
                lowrun = 0;
            end else begin
                lowrun++;
                if (started && lowrun > DH) gap = 1'b1;
            end
            prev = clk_out[0];
        end
        check(cnt == MO, "R6", "pulses before pending stop", cnt, MO);
        check(gap && resumed, "R6", "gap then restart", int'({gap, resumed}), 3);

        // R8: clearing an enable during a high phase lets it finish
        repeat (60) @(negedge clk);
        found = 1'b0; prev = clk_out[1]; k = 0;
        while (!found && k < 40) begin
            @(negedge clk);
            if (clk_out[1] && !prev) found = 1'b1;
            prev = clk_out[1];
            k++;
        end
        out_en[1] = 1'b0;
        @(negedge clk);
        check(found && clk_out[1], "R8", "high phase completes after disable",
              int'(clk_out[1]), 1);
        @(negedge clk);
        seen_hi = '0; seen_lo = '0;
        repeat (20) begin
            @(negedge clk);
            seen_hi |= clk_out;
            seen_lo |= ~clk_out;
        end
        check(!seen_hi[1] && seen_hi[0] && seen_lo[0], "R8", "disabled lane held low",
              int'(seen_hi), 13);
        out_en[1] = 1'b1;
        repeat (20) @(negedge clk);

        // R4: width monitor summary
        check(width_errs == 0 && pulses_seen > 0, "R4", "high phase width errors",
              width_errs, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule